// File: doc/BRIEF.md
# Edge-Positioned Multi-Channel PWM Generator

This block produces up to sixteen pulse-width-modulated outputs from one shared timebase. An 8-bit prescaler divides the input clock into steps. An 8-bit step counter then counts steps until it reaches the programmed period and wraps to zero. Each channel does not hold a duty value. Instead it holds two absolute positions on the step counter: the step at which its output is driven high and the step at which it is driven low. Software programs everything through a flat register port with an address, write data, a write strobe and combinational read data.

Channels named in an elaboration mask carry a second, pending copy of their two edge registers. While the global deferred-update bit is set, writes to those channels land in the pending copy. The pending copy moves into the active copy when the step counter wraps, so a period that has already begun finishes with its old edges. Channels outside the mask, and all channels while the bit is clear, take new edge values on the next clock.

Each channel runs a three-state machine. In `CH_OFF` the output is low. The transition *arm* leads to `CH_LOW` when the enable bit is set. In `CH_LOW` the output is low, and the transition *rise* leads to `CH_HIGH` at the start of the step whose count equals the rising-edge value. In `CH_HIGH` the output is high, and the transition *fall* leads back to `CH_LOW` at the start of the step whose count equals the falling-edge value. The transition *disarm* leads from `CH_LOW` or `CH_HIGH` to `CH_OFF` whenever the enable bit is clear.

Top module: `pwm_edge_gen`

## Requirements
- R1: The prescale register (address 0x00) holds S and the period register (address 0x04) holds P. One output period lasts exactly (S+1)*(P+1) clocks.
- R2: When the rising-edge value R and the falling-edge value F differ and both are at most P, the output is high for ((F-R) mod (P+1))*(S+1) clocks of every period. The output changes one clock after the first clock of the matching step.
- R3: When R equals F and both are at most P, the output inverts once per period. This gives a 50% wave whose period is twice the programmed one.
- R4: An edge value above P never matches. If R > P, an enabled channel stays low. If R <= P < F, the channel stays high after its first rise.
- R5: Bit k of the register at 0x08 enables channel k (k = 0..7). Bit k of the register at 0x0C enables channel 8+k. A disabled channel drives its output low within two clocks.
- R6: Channel i has its rising-edge register at 0x10+8*i and its falling-edge register at 0x14+8*i. Both are 8 bits wide and read back their active value.
- R7: Bit 0 of the register at 0xE4 is the deferred-update bit. When it is set, a write to a channel inside SHADOW_MASK leaves the active edge, and its read-back, unchanged until the step counter wraps. The new edge then governs the following period.
- R8: When the deferred-update bit is clear, or the channel is outside SHADOW_MASK, an edge write is active and readable on the next clock.
- R9: After reset every register reads 0 and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe, one write per clock |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The main function is swept over three prescale values, two period lengths and every pair of edge positions from 0 to P+1. Rising-before-falling pairs test plain duty arithmetic. Falling-before-rising pairs test the wrap across the period boundary. Equal pairs separate toggling from a stuck output, and out-of-range values separate a never-firing edge from an aliased one. The interval between consecutive rising edges pins the period length. A separate pattern, aligned to a period start, writes a deferred edge and compares its read-back and the following high time against a write to a channel outside the mask. This separates pending storage from immediate storage.

// File: rtl/pwm_edge_pkg.sv
`timescale 1ns/1ps
package pwm_edge_pkg;
    localparam int REG_W = 8;
    localparam logic [7:0] A_PRESCALE  = 8'h00;
    localparam logic [7:0] A_PERIOD    = 8'h04;
    localparam logic [7:0] A_EN_LO     = 8'h08;
    localparam logic [7:0] A_EN_HI     = 8'h0C;
    localparam logic [7:0] A_SYNC      = 8'hE4;
    localparam int         EDGE_BASE   = 16;
    localparam int         EDGE_STRIDE = 8;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_LOW  = 2'd1,
        CH_HIGH = 2'd2
    } ch_state_e;
endpackage

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] prescale,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         step,
    output logic         wrap
);
    logic [W-1:0] pre_cnt;
    logic         tick;

    always_comb begin
        tick = (pre_cnt >= prescale);
        step = (pre_cnt == '0);
        wrap = tick && (cnt >= period);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            cnt     <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
            cnt     <= (cnt >= period) ? '0 : cnt + 1'b1;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    // R1: a wrap starts a fresh period on the next clock
    p_wrap_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt == '0 && step));

    // R1: the step counter only moves at the end of a prescaled step
    p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt));
endmodule

// File: rtl/pwm_edge_reg.sv
`timescale 1ns/1ps
module pwm_edge_reg #(
    parameter int W          = 8,
    parameter bit HAS_SHADOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         sync_en,
    input  logic         wrap,
    output logic [W-1:0] act
);
    logic immediate;
    assign immediate = wr && (!sync_en || !HAS_SHADOW);

    if (HAS_SHADOW) begin : g_shadow
        logic [W-1:0] pend;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend <= '0;
                act  <= '0;
            end else begin
                if (wr) pend <= wdata;
                if (wr && !sync_en) act <= wdata;
                else if (wrap)      act <= pend;
            end
        end
    end else begin : g_direct
        always_ff @(posedge clk) begin
            if (!rst_n)  act <= '0;
            else if (wr) act <= wdata;
        end
    end

    // R7: the active edge only moves on a wrap or an immediate write
    p_pending_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !immediate) |=> $stable(act));

    // R8: an immediate write is visible on the next clock
    p_immediate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        immediate |=> (act == $past(wdata)));
endmodule

// File: rtl/pwm_regfile.sv
`timescale 1ns/1ps
module pwm_regfile
    import pwm_edge_pkg::*;
#(
    parameter int          NUM_CH      = 16,
    parameter logic [15:0] SHADOW_MASK = 16'h00FF,
    parameter int          W           = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [7:0]                 addr,
    input  logic [W-1:0]               wdata,
    input  logic                       we,
    input  logic                       wrap,
    output logic [W-1:0]               rdata,
    output logic [W-1:0]               prescale,
    output logic [W-1:0]               period,
    output logic [NUM_CH-1:0]          ch_en,
    output logic [NUM_CH-1:0][W-1:0]   rise_act,
    output logic [NUM_CH-1:0][W-1:0]   fall_act
);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int MAP_END = EDGE_BASE + EDGE_STRIDE * NUM_CH;

    logic [W-1:0]  en_lo, en_hi;
    logic [15:0]   en_all;
    logic          sync_en;
    logic          edge_hit;
    logic          is_fall;
    logic [7:0]    off;
    logic [CH_W-1:0] ch_sel;

    always_comb begin
        off      = addr - 8'(EDGE_BASE);
        edge_hit = (int'(addr) >= EDGE_BASE) && (int'(addr) < MAP_END)
                   && (addr[1:0] == 2'b00);
        is_fall  = off[2];
        ch_sel   = CH_W'(off >> 3);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prescale <= '0;
            period   <= '0;
            en_lo    <= '0;
            en_hi    <= '0;
            sync_en  <= 1'b0;
        end else if (we) begin
            case (addr)
                A_PRESCALE: prescale <= wdata;
                A_PERIOD:   period   <= wdata;
                A_EN_LO:    en_lo    <= wdata;
                A_EN_HI:    en_hi    <= wdata;
                A_SYNC:     sync_en  <= wdata[0];
                default: ;
            endcase
        end
    end

    assign en_all = {en_hi, en_lo};
    assign ch_en  = en_all[NUM_CH-1:0];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [W-1:0] r_q, f_q;
        logic         wr_r, wr_f;
        assign wr_r = we && edge_hit && (ch_sel == CH_W'(i)) && !is_fall;
        assign wr_f = we && edge_hit && (ch_sel == CH_W'(i)) &&  is_fall;

        pwm_edge_reg #(.W(W), .HAS_SHADOW(SHADOW_MASK[i])) u_rise (
            .clk(clk), .rst_n(rst_n), .wr(wr_r), .wdata(wdata),
            .sync_en(sync_en), .wrap(wrap), .act(r_q));
        pwm_edge_reg #(.W(W), .HAS_SHADOW(SHADOW_MASK[i])) u_fall (
            .clk(clk), .rst_n(rst_n), .wr(wr_f), .wdata(wdata),
            .sync_en(sync_en), .wrap(wrap), .act(f_q));

        assign rise_act[i] = r_q;
        assign fall_act[i] = f_q;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_PRESCALE: rdata = prescale;
            A_PERIOD:   rdata = period;
            A_EN_LO:    rdata = en_lo;
            A_EN_HI:    rdata = en_hi;
            A_SYNC:     rdata = W'(sync_en);
            default: begin
                if (edge_hit) rdata = is_fall ? fall_act[ch_sel] : rise_act[ch_sel];
            end
        endcase
    end

    // R5: the enable registers change only when written
    p_enable_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(ch_en));
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
    import pwm_edge_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] rise,
    input  logic [W-1:0] fall,
    output logic         out
);
    ch_state_e state, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CH_OFF:  nxt = en ? CH_LOW : CH_OFF;
            CH_LOW: begin
                if (!en)                        nxt = CH_OFF;
                else if (step && cnt == rise)   nxt = CH_HIGH;
            end
            CH_HIGH: begin
                if (!en)                        nxt = CH_OFF;
                else if (step && cnt == fall)   nxt = CH_LOW;
            end
            default: nxt = CH_OFF;
        endcase
    end

    always_comb out = (state == CH_HIGH);

    // R5: a disabled channel is low on the next clock
    p_off_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !out);

    // R2: a rising match drives the output high
    p_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == CH_LOW && step && cnt == rise) |=> out);

    // R2: a falling match drives the output low
    p_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && out && step && cnt == fall) |=> !out);

    // R2: between step starts an enabled output holds its level
    p_step_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !step) |=> $stable(out));
endmodule

// File: rtl/pwm_edge_gen.sv
`timescale 1ns/1ps
module pwm_edge_gen #(
    parameter int          NUM_CH      = 16,
    parameter logic [15:0] SHADOW_MASK = 16'h00FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int W = pwm_edge_pkg::REG_W;

    logic [W-1:0]             prescale, period, cnt;
    logic                     step, wrap;
    logic [NUM_CH-1:0]        ch_en;
    logic [NUM_CH-1:0][W-1:0] rise_act, fall_act;

    pwm_timebase #(.W(W)) u_timebase (
        .clk(clk), .rst_n(rst_n), .prescale(prescale), .period(period),
        .cnt(cnt), .step(step), .wrap(wrap));

    pwm_regfile #(.NUM_CH(NUM_CH), .SHADOW_MASK(SHADOW_MASK), .W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wdata(reg_wdata),
        .we(reg_we), .wrap(wrap), .rdata(reg_rdata), .prescale(prescale),
        .period(period), .ch_en(ch_en), .rise_act(rise_act), .fall_act(fall_act));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        pwm_channel #(.W(W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(ch_en[i]), .step(step), .cnt(cnt),
            .rise(rise_act[i]), .fall(fall_act[i]), .out(pwm_out[i]));
    end
endmodule

// File: tb/pwm_edge_gen_bench.sv
`timescale 1ns/1ps
module pwm_edge_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic        we = 1'b0;
    logic [7:0]  rdata;
    logic [15:0] pwm_out;
    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    pwm_edge_gen u_pwm_edge_gen (
        .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_wdata(wdata),
        .reg_we(we), .reg_rdata(rdata), .pwm_out(pwm_out));

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            errors++;
            $display("FAIL watchdog expired actual %0d expected <190000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        prev = pwm_out[ch];
        forever begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    initial begin
        logic [7:0] v;
        int t, win, hi, expv, n;
        logic prev;
        string req;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        check("R9 outputs", int'(pwm_out), 0);
        rd(8'h00, v); check("R9 prescale", v, 0);
        rd(8'h04, v); check("R9 period", v, 0);
        rd(8'h08, v); check("R9 en_lo", v, 0);
        rd(8'h0C, v); check("R9 en_hi", v, 0);
        rd(8'hE4, v); check("R9 sync", v, 0);
        rd(8'h10, v); check("R9 rise0", v, 0);
        rd(8'h8C, v); check("R9 fall15", v, 0);

        // R6: edge register map and readback
        for (int i = 0; i < 16; i++) begin
            wr(8'(16 + 8*i), 8'(3*i + 1));
            wr(8'(20 + 8*i), 8'(5*i + 2));
        end
        for (int i = 0; i < 16; i++) begin
            rd(8'(16 + 8*i), v); check("R6 rise readback", v, 3*i + 1);
            rd(8'(20 + 8*i), v); check("R6 fall readback", v, 5*i + 2);
        end

        // R1 R2 R3 R4: sweep of timebase and edge positions on channel 0
        for (int s = 0; s < 3; s++) begin
            for (int p = 3; p <= 5; p += 2) begin
                t = (s + 1) * (p + 1);
                wr(8'h00, 8'(s));
                wr(8'h04, 8'(p));
                for (int r = 0; r <= p + 1; r++) begin
                    for (int f = 0; f <= p + 1; f++) begin
                        wr(8'h08, 8'h00);
                        wr(8'h10, 8'(r));
                        wr(8'h14, 8'(f));
                        wr(8'h08, 8'h01);
                        repeat (2*t) @(negedge clk);
                        win = (r == f && r <= p) ? 2*t : t;
                        hi = 0;
                        repeat (win) begin
                            @(negedge clk);
                            hi += int'(pwm_out[0]);
                        end
                        if (r > p)       begin expv = 0; req = "R4 rise out of range"; end
                        else if (f > p)  begin expv = t; req = "R4 fall out of range"; end
                        else if (r == f) begin expv = t; req = "R3 equal edges"; end
                        else if (r < f)  begin expv = (f - r) * (s + 1); req = "R2 duty"; end
                        else             begin expv = (p + 1 - (r - f)) * (s + 1); req = "R2 wrapped duty"; end
                        check(req, hi, expv);
                    end
                end
                // R1: rising-to-rising interval
                wr(8'h08, 8'h00);
                wr(8'h10, 8'h00);
                wr(8'h14, 8'h01);
                wr(8'h08, 8'h01);
                repeat (2*t) @(negedge clk);
                wait_rise(0);
                n = 0;
                prev = 1'b1;
                forever begin
                    @(negedge clk);
                    n++;
                    if (pwm_out[0] && !prev) break;
                    prev = pwm_out[0];
                end
                check("R1 period length", n, t);
            end
        end

        // R5: enable bit decode for the upper and lower registers
        wr(8'h08, 8'h00);
        wr(8'h00, 8'h00);
        wr(8'h04, 8'h03);
        wr(8'h88, 8'h00); wr(8'h8C, 8'h09);
        wr(8'h50, 8'h00); wr(8'h54, 8'h09);
        wr(8'h0C, 8'h80);
        repeat (10) @(negedge clk);
        check("R5 channel 15 only", int'(pwm_out), 16'h8000);
        wr(8'h0C, 8'h81);
        repeat (10) @(negedge clk);
        check("R5 channels 8 and 15", int'(pwm_out), 16'h8100);
        wr(8'h0C, 8'h00);
        repeat (2) @(negedge clk);
        check("R5 disabled low", int'(pwm_out), 0);

        // R7 R8: deferred update aligned to a period start
        wr(8'hE4, 8'h00);
        wr(8'h00, 8'h00);
        wr(8'h04, 8'd200);
        wr(8'h10, 8'd0);
        wr(8'h14, 8'd100);
        wr(8'h08, 8'h01);
        wait_rise(0);
        wait_rise(0);
        wr(8'hE4, 8'h01);
        wr(8'h14, 8'd150);
        rd(8'h14, v); check("R7 pending not visible", v, 100);
        wr(8'h8C, 8'd33);
        rd(8'h8C, v); check("R8 unshadowed channel immediate", v, 33);
        wait_rise(0);
        hi = 1;
        forever begin
            @(negedge clk);
            if (!pwm_out[0]) break;
            hi++;
        end
        check("R7 new edge governs next period", hi, 150);
        rd(8'h14, v); check("R7 readback after wrap", v, 150);
        wr(8'hE4, 8'h00);
        wr(8'h14, 8'd60);
        rd(8'h14, v); check("R8 sync clear immediate", v, 60);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule